// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block drives a 3-wire serial EEPROM (chip select, serial clock, data to the device, data from the device). It has two jobs. The first runs only after a hard reset. When the strap input is high, it reads a fixed number of 16-bit words from addresses 0 upward. Each word comes out as a one-cycle pulse on a simple load bus. When that read is finished, an init-done flag is raised.

The second job serves software. A single 32-bit status/control register lets software request a write-enable or write-disable command. Each request bit clears itself when its serial frame has been shifted out. An idle flag tells software whether the sequencer is free.

The serial clock period is `CLK_DIV` system clocks: the first half is low and the second half is high. Data to the device changes only when the serial clock falls. Data from the device is sampled on the last system clock of the high half. Chip select stays low for more than one serial period between frames.

The controller states and their transitions are:
- `ST_BOOT`: goes to `ST_LD_SHIFT` if the strap is high, otherwise to `ST_IDLE`.
- `ST_LD_SHIFT`: goes to `ST_LD_GAP` when a read frame ends.
- `ST_LD_GAP`: after the gap, goes back to `ST_LD_SHIFT` for the next word, or to `ST_IDLE` after the last word.
- `ST_IDLE`: goes to `ST_CMD_SHIFT` on an accepted request.
- `ST_CMD_SHIFT`: goes to `ST_CMD_GAP` when the command frame ends.
- `ST_CMD_GAP`: goes to `ST_IDLE` after the gap.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: While reset is held, `reg_rdata` reads 0. After reset with the strap low, it settles to 0x4 (only the idle bit set).
- R2: With the strap high after reset, the block reads words 0 to `LOAD_WORDS`-1 in order.
  - Each read frame is 26 bits: start 1, opcode 10, a 6-bit address MSB first, then a dummy bit and 16 data bits.
  - Each word appears on `load_addr`/`load_data` with a one-cycle `load_valid` pulse.
  - Afterwards, bit 3 (init done) reads 1. With the strap low, no frame is sent and bit 3 stays 0.
- R3: `ee_sk` is high only while `ee_cs` is high. Each serial period is `CLK_DIV` clocks, low half first. `ee_mosi` holds steady while `ee_sk` is high.
- R4: `ee_cs` stays low for at least `CLK_DIV` clocks between two frames.
- R5: Bit 2 (idle) reads 1 only when no command and no autoload is in progress. Whenever idle reads 1, `ee_cs` is low.
- R6: Writing 1 to bit 1 while idle sends the 9-bit write-enable frame 1_00_110000. Bit 1 reads 1 until that frame ends, then reads 0.
- R7: Writing 1 to bit 0 while idle sends the 9-bit write-disable frame 1_00_000000. Bit 0 reads 1 until that frame ends, then reads 0.
- R8: Writing 1 to bits 0 and 1 together sends only the write-disable frame, and only bit 0 reads 1.
- R9: A request written during autoload, or while a command is running, is dropped: no frame is sent and the request bits do not change.
- R10: Bits 31:4 of `reg_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset |
| strap_autoload | input | 1 | High: read the EEPROM after reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; bit 1 requests write-enable, bit 0 requests write-disable |
| reg_rdata | output | 32 | Status: bit 3 init done, bit 2 idle, bit 1 / bit 0 request pending |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data to the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |
| load_valid | output | 1 | One-cycle pulse per autoloaded word |
| load_addr | output | 6 | Address of the autoloaded word |
| load_data | output | 16 | Autoloaded word |

## Verification
The assertions check these properties on every cycle:
- the serial clock is confined to chip select;
- data to the device is stable during the high half;
- at most one request bit is set;
- no request is pending during autoload;
- the engine is stopped during every gap state and whenever idle is reported.

Only the bench's scenarios can show the rest: the exact bit patterns of the read, write-enable and write-disable frames; the words delivered on the load bus; the priority of write-disable; dropped requests; and the length of the chip-select gaps. For these, the bench decodes the pins with its own device model and returns data that it computes itself.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    localparam int FRAME_W   = 26;
    localparam int CMD_BITS  = 9;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int BITS_W    = $clog2(FRAME_W + 1);

    localparam logic [1:0] OP_READ = 2'b10;
    localparam logic [1:0] OP_MISC = 2'b00;
    localparam logic [ADDR_W-1:0] SUB_ENABLE  = 6'b110000;
    localparam logic [ADDR_W-1:0] SUB_DISABLE = 6'b000000;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LD_SHIFT,
        ST_LD_GAP,
        ST_IDLE,
        ST_CMD_SHIFT,
        ST_CMD_GAP
    } seq_state_t;

    // Left-aligned frame: start bit, opcode, address; trailing bits are zero.
    function automatic logic [FRAME_W-1:0] make_frame(input logic [1:0] op,
                                                      input logic [ADDR_W-1:0] adr);
        return {1'b1, op, adr, {(FRAME_W - CMD_BITS){1'b0}}};
    endfunction

endpackage

// File: rtl/eeprom_bit_engine.sv
module eeprom_bit_engine
    import eeprom_seq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic [BITS_W-1:0]  tx_bits,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic               cs,
    output logic               sk,
    output logic               mosi,
    output logic [DATA_W-1:0]  rx_word
);

    localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLK_DIV / 2);

    logic               run_q;
    logic               done_q;
    logic [PH_W-1:0]    ph_q;
    logic [BITS_W-1:0]  left_q;
    logic [FRAME_W-1:0] sreg_q;
    logic [DATA_W-1:0]  rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            ph_q   <= '0;
            left_q <= '0;
            sreg_q <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q  <= 1'b1;
                    ph_q   <= '0;
                    sreg_q <= tx_word;
                    left_q <= tx_bits;
                end
            end else if (ph_q == PH_LAST) begin
                ph_q   <= '0;
                sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
                rx_q   <= {rx_q[DATA_W-2:0], miso};
                left_q <= left_q - 1'b1;
                if (left_q == BITS_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy    = run_q;
        done    = done_q;
        cs      = run_q;
        sk      = run_q && (ph_q >= PH_HALF);
        mosi    = run_q && sreg_q[FRAME_W-1];
        rx_word = rx_q;
    end

    // R3: serial clock confined to chip select
    a_r3_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sk);

    // R3: outgoing data holds while the serial clock is high
    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(mosi));

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
    import eeprom_seq_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int LOAD_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_autoload,
    input  logic               req_wr,
    input  logic               req_enable,
    input  logic               req_disable,
    input  logic               eng_busy,
    input  logic               eng_done,
    input  logic [DATA_W-1:0]  eng_rx,
    output logic               eng_start,
    output logic [FRAME_W-1:0] eng_word,
    output logic [BITS_W-1:0]  eng_bits,
    output logic               load_valid,
    output logic [ADDR_W-1:0]  load_addr,
    output logic [DATA_W-1:0]  load_data,
    output logic               init_done,
    output logic               idle,
    output logic               pend_enable,
    output logic               pend_disable
);

    localparam int IDX_W = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1;
    localparam int GAP_W = $clog2(CLK_DIV + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LOAD_WORDS - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CLK_DIV - 1);

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [GAP_W-1:0]  gap_q;
    logic [1:0]        pend_q;      // {enable, disable}
    logic              init_q;
    logic              in_gap, gap_end, last_word, accept;

    assign in_gap    = (state_q == ST_LD_GAP) || (state_q == ST_CMD_GAP);
    assign gap_end   = in_gap && (gap_q == GAP_LAST);
    assign last_word = (idx_q == IDX_LAST);
    assign accept    = (state_q == ST_IDLE) && req_wr && (req_enable || req_disable);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state and frame launch
    always_comb begin
        state_d   = state_q;
        eng_start = 1'b0;
        eng_word  = '0;
        eng_bits  = BITS_W'(FRAME_W);
        unique case (state_q)
            ST_BOOT: begin
                if (strap_autoload) begin
                    state_d   = ST_LD_SHIFT;
                    eng_start = 1'b1;
                    eng_word  = make_frame(OP_READ, '0);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_LD_SHIFT: if (eng_done) state_d = ST_LD_GAP;
            ST_LD_GAP: begin
                if (gap_end) begin
                    if (last_word) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d   = ST_LD_SHIFT;
                        eng_start = 1'b1;
                        eng_word  = make_frame(OP_READ, ADDR_W'(idx_q) + 1'b1);
                    end
                end
            end
            ST_IDLE: begin
                if (accept) begin
                    state_d   = ST_CMD_SHIFT;
                    eng_start = 1'b1;
                    eng_bits  = BITS_W'(CMD_BITS);
                    eng_word  = req_disable ? make_frame(OP_MISC, SUB_DISABLE)
                                            : make_frame(OP_MISC, SUB_ENABLE);
                end
            end
            ST_CMD_SHIFT: if (eng_done) state_d = ST_CMD_GAP;
            ST_CMD_GAP:   if (gap_end)  state_d = ST_IDLE;
            default:      state_d = ST_BOOT;
        endcase
    end

    // Counters, pending bits and init flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            gap_q  <= '0;
            pend_q <= 2'b00;
            init_q <= 1'b0;
        end else begin
            gap_q <= in_gap ? gap_q + 1'b1 : '0;
            if ((state_q == ST_LD_GAP) && gap_end) begin
                if (last_word) init_q <= 1'b1;
                else           idx_q  <= idx_q + 1'b1;
            end
            if (accept)
                pend_q <= req_disable ? 2'b01 : 2'b10;
            else if ((state_q == ST_CMD_SHIFT) && eng_done)
                pend_q <= 2'b00;
        end
    end

    // Outputs
    always_comb begin
        load_valid   = (state_q == ST_LD_SHIFT) && eng_done;
        load_addr    = ADDR_W'(idx_q);
        load_data    = eng_rx;
        init_done    = init_q;
        idle         = (state_q == ST_IDLE);
        pend_enable  = pend_q[1];
        pend_disable = pend_q[0];
    end

    // R8: at most one command pending
    a_r8_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_q));

    // R9: no request taken while autoload runs
    a_r9_no_pend_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LD_SHIFT) || (state_q == ST_LD_GAP)) |-> (pend_q == 2'b00));

    // R4: engine stopped during every gap
    a_r4_gap_engine_off: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> !eng_busy);

    // R5: idle only with nothing in flight
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!eng_busy && pend_q == 2'b00));

    // R2: init flag never raised while words are still being read
    a_r2_init_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> !((state_q == ST_LD_SHIFT) || (state_q == ST_LD_GAP)));

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
    import eeprom_seq_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int LOAD_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_autoload,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_mosi,
    input  logic        ee_miso,
    output logic        load_valid,
    output logic [5:0]  load_addr,
    output logic [15:0] load_data
);

    logic               eng_start, eng_busy, eng_done;
    logic [FRAME_W-1:0] eng_word;
    logic [BITS_W-1:0]  eng_bits;
    logic [DATA_W-1:0]  eng_rx;
    logic               init_done, idle, pend_enable, pend_disable;

    eeprom_seq_ctrl #(
        .CLK_DIV    (CLK_DIV),
        .LOAD_WORDS (LOAD_WORDS)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_autoload (strap_autoload),
        .req_wr         (reg_wr),
        .req_enable     (reg_wdata[1]),
        .req_disable    (reg_wdata[0]),
        .eng_busy       (eng_busy),
        .eng_done       (eng_done),
        .eng_rx         (eng_rx),
        .eng_start      (eng_start),
        .eng_word       (eng_word),
        .eng_bits       (eng_bits),
        .load_valid     (load_valid),
        .load_addr      (load_addr),
        .load_data      (load_data),
        .init_done      (init_done),
        .idle           (idle),
        .pend_enable    (pend_enable),
        .pend_disable   (pend_disable)
    );

    eeprom_bit_engine #(
        .CLK_DIV (CLK_DIV)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_word (eng_word),
        .tx_bits (eng_bits),
        .miso    (ee_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .cs      (ee_cs),
        .sk      (ee_sk),
        .mosi    (ee_mosi),
        .rx_word (eng_rx)
    );

    assign reg_rdata = {28'd0, init_done, idle, pend_enable, pend_disable};

    // R5: chip select low whenever idle is reported
    a_r5_idle_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[2] |-> !ee_cs);

endmodule

// File: tb/sim_eeprom_cmd_seq.sv
module sim_eeprom_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int LW         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_cs, ee_sk, ee_mosi;
    logic        ee_miso = 1'b0;
    logic        load_valid;
    logic [5:0]  load_addr;
    logic [15:0] load_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_cmd_seq #(.CLK_DIV(DIV), .LOAD_WORDS(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_autoload(strap),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi), .ee_miso(ee_miso),
        .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data)
    );

    function automatic logic [15:0] dev_word(input logic [5:0] a);
        return {a, a, a[3:0]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural device and pin model
    logic [31:0] fr_q[$];
    int          len_q[$];
    logic [31:0] fbits;
    int          flen, gap, lv_count, exp_addr, last_rise, cyc;
    logic [8:0]  cmd9;
    logic        sk_d, cs_d, mosi_at_rise, had_frame;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst_n) begin
            fbits = '0; flen = 0; gap = 0; sk_d = 0; cs_d = 0;
            had_frame = 0; ee_miso = 0; cmd9 = '0;
        end else begin
            chk(reg_rdata[31:4] == 28'd0, "R10", "reserved bits", reg_rdata, {28'd0, reg_rdata[3:0]});
            chk(!(ee_sk && !ee_cs), "R3", "sk outside cs", {31'd0, ee_sk}, 32'd0);
            chk(!(reg_rdata[2] && ee_cs), "R5", "cs while idle", {31'd0, ee_cs}, 32'd0);
            if (ee_cs && !cs_d) begin
                if (had_frame) chk(gap >= DIV, "R4", "cs low gap", gap, DIV);
            end
            if (ee_cs && ee_sk && !sk_d) begin
                if (flen > 0) chk(cyc - last_rise == DIV, "R3", "sk period", cyc - last_rise, DIV);
                last_rise = cyc;
                fbits = {fbits[30:0], ee_mosi};
                mosi_at_rise = ee_mosi;
                if (flen == 8) cmd9 = fbits[8:0];
                if (flen >= 9 && cmd9[7:6] == 2'b10 && flen <= 25)
                    ee_miso = (flen == 9) ? 1'b0 : dev_word(cmd9[5:0])[15 - (flen - 10)];
                flen++;
            end else if (ee_sk && sk_d) begin
                chk(ee_mosi == mosi_at_rise, "R3", "mosi moved while sk high", ee_mosi, mosi_at_rise);
            end
            if (!ee_cs && cs_d) begin
                fr_q.push_back(fbits); len_q.push_back(flen);
                fbits = '0; flen = 0; gap = 0; had_frame = 1;
            end
            if (!ee_cs) gap++;
            if (load_valid) begin
                chk(load_addr == 6'(exp_addr), "R2", "load addr", load_addr, exp_addr);
                chk(load_data == dev_word(load_addr), "R2", "load data", load_data, dev_word(load_addr));
                exp_addr++; lv_count++;
            end
            sk_d = ee_sk; cs_d = ee_cs;
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && !reg_rdata[2]; i++) @(negedge clk);
    endtask

    task automatic expect_one_frame(input string req, input logic [8:0] pat);
        chk(fr_q.size() == 1, req, "frame count", fr_q.size(), 1);
        if (fr_q.size() > 0) begin
            chk(len_q[0] == 9, req, "frame length", len_q[0], 9);
            chk(fr_q[0][8:0] == pat, req, "frame bits", fr_q[0], {23'd0, pat});
        end
        fr_q.delete(); len_q.delete();
    endtask

    task automatic do_reset(input logic s);
        strap = s; rst_n = 1'b0;
        lv_count = 0; exp_addr = 0;
        repeat (3) @(negedge clk);
        chk(reg_rdata == 32'd0, "R1", "value during reset", reg_rdata, 32'd0);
        fr_q.delete(); len_q.delete();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc = 0; lv_count = 0; exp_addr = 0; last_rise = 0;
        // Autoload with a request dropped mid-load
        do_reset(1'b1);
        repeat (20) @(negedge clk);
        wr(32'h3);
        chk(reg_rdata[2:0] == 3'b000, "R9", "request during autoload", reg_rdata, 32'd0);
        for (int i = 0; i < 5000 && !reg_rdata[3]; i++) @(negedge clk);
        chk(reg_rdata == 32'hC, "R2", "status after autoload", reg_rdata, 32'hC);
        chk(lv_count == LW, "R2", "words delivered", lv_count, LW);
        chk(fr_q.size() == LW, "R9", "no extra frames in autoload", fr_q.size(), LW);
        for (int i = 0; i < LW && fr_q.size() > 0; i++) begin
            chk(len_q[0] == 26, "R2", "read frame length", len_q[0], 26);
            chk(fr_q[0][25:17] == {3'b110, 6'(i)}, "R2", "read frame head",
                fr_q[0][25:17], {3'b110, 6'(i)});
            void'(fr_q.pop_front()); void'(len_q.pop_front());
        end
        // Write enable
        wr(32'h2);
        chk(reg_rdata[2:0] == 3'b010, "R6", "enable pending", reg_rdata, 32'hA);
        wait_idle();
        chk(reg_rdata[1:0] == 2'b00, "R6", "enable cleared", reg_rdata, 32'hC);
        expect_one_frame("R6", 9'b1_00_110000);
        // Write disable
        wr(32'h1);
        chk(reg_rdata[2:0] == 3'b001, "R7", "disable pending", reg_rdata, 32'h9);
        wait_idle();
        chk(reg_rdata[1:0] == 2'b00, "R7", "disable cleared", reg_rdata, 32'hC);
        expect_one_frame("R7", 9'b1_00_000000);
        // Both bits: disable wins; a request during the command is dropped
        wr(32'h3);
        chk(reg_rdata[1:0] == 2'b01, "R8", "priority bits", reg_rdata[1:0], 2'b01);
        wr(32'h2);
        chk(reg_rdata[1:0] == 2'b01, "R9", "request while busy", reg_rdata[1:0], 2'b01);
        wait_idle();
        repeat (2 * DIV) @(negedge clk);
        expect_one_frame("R8", 9'b1_00_000000);
        // Write of zero starts nothing
        wr(32'h0);
        repeat (20) @(negedge clk);
        chk(fr_q.size() == 0, "R5", "no frame for zero write", fr_q.size(), 0);
        chk(reg_rdata == 32'hC, "R5", "idle after zero write", reg_rdata, 32'hC);
        // Strap off
        do_reset(1'b0);
        repeat (300) @(negedge clk);
        chk(reg_rdata == 32'h4, "R1", "status with strap off", reg_rdata, 32'h4);
        chk(fr_q.size() == 0, "R2", "no frame with strap off", fr_q.size(), 0);
        chk(lv_count == 0, "R2", "no load with strap off", lv_count, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule